// File: doc/BRIEF.md
# EDO DRAM Write-Cycle Sequencer

This block turns one host request into the strobe sequence of a single write-type access on an asynchronous EDO DRAM. It supports three cycle types, and the host chooses one on each request: early write, late write and read-modify-write. The cycle type is set by when the write strobe falls relative to the column strobe. That timing also decides whether the DRAM's data pins stay open or first return the addressed cell's contents. Parameters give every interval in clock cycles: row-to-column delay, write setup, column low width, column-to-write delay, output-enable hold, row precharge, column precharge and refresh pulse.

The host presents an op code, a row, a column, write data and a hidden-refresh flag. The request is taken while `reqReady` is high. The block then drives the multiplexed address, the four active-low strobes and the controller-side data drive enable. At the end of every accepted request it raises `doneValid` for one cycle. For a read-modify-write, `doneRdata` then carries the data sampled from the DRAM. If the request asks for a hidden refresh, one refresh pulse is appended after the write while the column strobe stays low. A build option covers boards where the output-enable pin is strapped low.

Top module: `edoWriteSeq`

## Requirements
- R1: After reset, all four strobes are high, the data drive enable is low, `reqReady` is high and `doneValid` is low.
- R2: Early write (op code 0): `dramWeN` falls exactly T_WCS cycles before `dramCasN` falls, `dramOeN` stays high for the whole cycle, and `reqWdata` is driven on `dramDqOut` with `dramDqOe` high in the first column-low cycle.
- R3: Late write (op code 1): `dramWeN` falls exactly T_CWD cycles after `dramCasN` falls, `dramOeN` stays high throughout, and the data drive is off until the cycle in which `dramWeN` falls.
- R4: Read-modify-write (op code 2): `dramOeN` is low for exactly the T_CWD cycles that start when `dramCasN` falls. It is then high for T_OEH cycles before `dramWeN` falls. `dramDqIn` is sampled in the last OE-low cycle and is presented on `doneRdata` in the cycle where `doneValid` is high.
- R5: `dramDqOe` is never high while `dramOeN` is low (outside the OE-strapped build).
- R6: `dramRasN` falls with the row on `dramAddr` and stays low at least T_RCD cycles before `dramCasN` falls. The column is on `dramAddr` from the end of that delay.
- R7: Between two requests, `dramCasN` is high for at least T_CP cycles and `dramRasN` for at least T_RP cycles.
- R8: With the hidden-refresh flag set, `dramRasN` rises while `dramCasN` stays low and falls again exactly T_RP cycles later. `dramWeN` stays low and `dramOeN` stays high at both of these edges.
- R9: Op code 3 is ignored: no strobe moves and no `doneValid` pulse follows.
- R10: In the OE-strapped build, `dramOeN` is always low and op codes 1 and 2 are ignored. After an early write, `dramWeN` stays low for the first column-high cycle and then rises while `dramCasN` is high.
- R11: `doneValid` is a single-cycle pulse in the last cycle of the request, and `reqReady` is high in the following cycle. Cycle lengths: early T_RCD+T_WCS+T_CAS+T_PRE, late T_RCD+T_CWD+T_CAS+T_PRE, read-modify-write T_RCD+T_CWD+T_OEH+T_CAS+T_PRE, plus T_RP+T_REF with a hidden refresh. T_PRE is the larger of T_RP and T_CP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 2 | 0 early write, 1 late write, 2 read-modify-write, 3 no operation |
| reqHidRef | input | 1 | Append a hidden refresh after the write |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| reqWdata | input | DQ_W | Write data |
| reqReady | output | 1 | Sequencer idle, request taken this cycle if valid |
| doneValid | output | 1 | One-cycle end-of-request pulse |
| doneRdata | output | DQ_W | Data sampled during read-modify-write |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed address |
| dramDqOut | output | DQ_W | Data toward the DRAM |
| dramDqOe | output | 1 | Controller data drive enable |
| dramDqIn | input | DQ_W | Data from the DRAM |

## Verification
A wrong phase or counter value shows directly as a shifted strobe edge: the setup gap, the column-to-write gap or the output-enable window, counted from the column strobe's fall, is off by at least one cycle. Such an error is therefore visible within one request. A bad next-phase decision shows as the wrong cycle type, for example an OE-low window in a write that should keep the bus open, or a drive enable overlapping output enable. It can also show as a `doneValid` pulse that comes at the wrong cycle count or not at all. A fault in the data path shows as the wrong value on `doneRdata` or `dramDqOut` in the very cycle where it is sampled.

// File: rtl/edoSeqPkg.sv
package edoSeqPkg;

  typedef enum logic [1:0] {
    OP_EARLY = 2'd0,
    OP_LATE  = 2'd1,
    OP_RMW   = 2'd2,
    OP_NOP   = 2'd3
  } opE;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ROWA,   // row strobe low, row address out
    PH_WSET,   // early write: write strobe low ahead of column
    PH_ECAS,   // early write: column low
    PH_LCAS,   // late write: column low, write strobe still high
    PH_LWE,    // late write: write strobe low
    PH_RREAD,  // rmw: column low, output enable low
    PH_ROFF,   // rmw: output enable back high, bus turnaround
    PH_RWE,    // rmw: write strobe low
    PH_HPRE,   // hidden refresh: row precharge under column low
    PH_HRAS,   // hidden refresh: row pulse
    PH_PRE     // all strobes high: row and column precharge
  } phaseE;

  typedef struct packed {
    logic loadReq;
    logic selCol;
    logic driveDq;
    logic captureRd;
  } strobeT;

endpackage

// File: rtl/edoSeqData.sv
module edoSeqData
  import edoSeqPkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int DQ_W  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DQ_W-1:0]   reqWdata,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqOe,
  output logic [DQ_W-1:0]   rdata
);

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [DQ_W-1:0]  wdataQ;
  logic [DQ_W-1:0]  rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (strobe.loadReq) begin
        rowQ   <= reqRow;
        colQ   <= reqCol;
        wdataQ <= reqWdata;
        rdataQ <= '0;
      end else if (strobe.captureRd) begin
        rdataQ <= dqIn;
      end
    end
  end

  assign addr  = strobe.selCol ? ADDR_W'(colQ) : ADDR_W'(rowQ);
  assign dqOut = wdataQ;
  assign dqOe  = strobe.driveDq;
  assign rdata = rdataQ;

endmodule

// File: rtl/edoSeqCtrl.sv
module edoSeqCtrl
  import edoSeqPkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_WCS = 1,
  parameter int T_CAS = 2,
  parameter int T_CWD = 3,
  parameter int T_OEH = 1,
  parameter int T_RP  = 3,
  parameter int T_CP  = 2,
  parameter int T_REF = 3,
  parameter bit OE_TIED = 1'b0,
  localparam int T_PRE = (T_RP > T_CP) ? T_RP : T_CP,
  localparam int T_A = (T_RCD > T_WCS) ? T_RCD : T_WCS,
  localparam int T_B = (T_CAS > T_CWD) ? T_CAS : T_CWD,
  localparam int T_C = (T_OEH > T_REF) ? T_OEH : T_REF,
  localparam int T_AB = (T_A > T_B) ? T_A : T_B,
  localparam int T_CP2 = (T_C > T_PRE) ? T_C : T_PRE,
  localparam int T_MAX = (T_AB > T_CP2) ? T_AB : T_CP2,
  localparam int CNT_W = $clog2(T_MAX + 1),
  localparam int RUN_W = $clog2(T_CP + 2)
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  opE     reqOp,
  input  logic   reqHidRef,
  output logic   reqReady,
  output logic   doneValid,
  output logic   rasN,
  output logic   casN,
  output logic   weN,
  output logic   oeN,
  output strobeT strobe
);

  phaseE phase, nextPhase;
  logic [CNT_W-1:0] cnt;
  opE    curOp;
  logic  curHid;
  logic  accept, advance, opAllowed;
  int    nextLen;

  assign opAllowed = (reqOp != OP_NOP) && (!OE_TIED || reqOp == OP_EARLY);
  assign accept    = (phase == PH_IDLE) && reqValid && opAllowed;

  always_comb begin
    nextPhase = phase;
    nextLen   = 1;
    advance   = 1'b0;
    if (phase == PH_IDLE) begin
      if (accept) begin
        nextPhase = PH_ROWA;
        nextLen   = T_RCD;
        advance   = 1'b1;
      end
    end else if (cnt == '0) begin
      advance = 1'b1;
      case (phase)
        PH_ROWA: begin
          if (curOp == OP_EARLY) begin
            nextPhase = PH_WSET;  nextLen = T_WCS;
          end else if (curOp == OP_LATE) begin
            nextPhase = PH_LCAS;  nextLen = T_CWD;
          end else begin
            nextPhase = PH_RREAD; nextLen = T_CWD;
          end
        end
        PH_WSET:  begin nextPhase = PH_ECAS; nextLen = T_CAS; end
        PH_LCAS:  begin nextPhase = PH_LWE;  nextLen = T_CAS; end
        PH_RREAD: begin nextPhase = PH_ROFF; nextLen = T_OEH; end
        PH_ROFF:  begin nextPhase = PH_RWE;  nextLen = T_CAS; end
        PH_ECAS, PH_LWE, PH_RWE: begin
          if (curHid) begin
            nextPhase = PH_HPRE; nextLen = T_RP;
          end else begin
            nextPhase = PH_PRE;  nextLen = T_PRE;
          end
        end
        PH_HPRE:  begin nextPhase = PH_HRAS; nextLen = T_REF; end
        PH_HRAS:  begin nextPhase = PH_PRE;  nextLen = T_PRE; end
        default:  begin nextPhase = PH_IDLE; nextLen = 1; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      curOp  <= OP_NOP;
      curHid <= 1'b0;
    end else begin
      if (advance) begin
        phase <= nextPhase;
        cnt   <= CNT_W'(nextLen - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (accept) begin
        curOp  <= reqOp;
        curHid <= reqHidRef;
      end
    end
  end

  // strobe decode from the registered phase
  logic preFirst;
  assign preFirst = (phase == PH_PRE) && (cnt == CNT_W'(T_PRE - 1));

  always_comb begin
    rasN = 1'b1;
    casN = 1'b1;
    weN  = 1'b1;
    case (phase)
      PH_ROWA:  begin rasN = 1'b0; end
      PH_WSET:  begin rasN = 1'b0; weN = 1'b0; end
      PH_ECAS:  begin rasN = 1'b0; casN = 1'b0; weN = 1'b0; end
      PH_LCAS:  begin rasN = 1'b0; casN = 1'b0; end
      PH_LWE:   begin rasN = 1'b0; casN = 1'b0; weN = 1'b0; end
      PH_RREAD: begin rasN = 1'b0; casN = 1'b0; end
      PH_ROFF:  begin rasN = 1'b0; casN = 1'b0; end
      PH_RWE:   begin rasN = 1'b0; casN = 1'b0; weN = 1'b0; end
      PH_HPRE:  begin casN = 1'b0; weN = 1'b0; end
      PH_HRAS:  begin rasN = 1'b0; casN = 1'b0; weN = 1'b0; end
      PH_PRE:   begin weN = !(OE_TIED && preFirst); end
      default:  ;
    endcase
  end

  generate
    if (OE_TIED) begin : gTied
      assign oeN = 1'b0;
    end else begin : gOe
      assign oeN = (phase != PH_RREAD);
    end
  endgenerate

  assign strobe.loadReq   = accept;
  assign strobe.selCol    = (phase != PH_ROWA);
  assign strobe.driveDq   = (phase == PH_WSET) || (phase == PH_ECAS) ||
                            (phase == PH_LWE)  || (phase == PH_RWE);
  assign strobe.captureRd = (phase == PH_RREAD) && (cnt == '0);

  assign reqReady  = (phase == PH_IDLE);
  assign doneValid = (phase == PH_PRE) && (cnt == '0);

  // column-high run length, for the precharge check
  logic [RUN_W-1:0] casHighRun;
  always_ff @(posedge clk) begin
    if (!rstN) casHighRun <= '0;
    else if (!casN) casHighRun <= '0;
    else if (casHighRun != {RUN_W{1'b1}}) casHighRun <= casHighRun + 1'b1;
  end

  assert_early_setup_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(casN) && curOp == OP_EARLY) |-> (!weN && $past(!weN)));

  assert_late_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(weN) && curOp == OP_LATE) |-> (!casN && $past(!casN)));

  assert_oe_turnaround_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(weN) && curOp == OP_RMW) |-> (oeN && $past(oeN)));

  assert_cas_precharge_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> (casHighRun >= RUN_W'(T_CP)));

  assert_hidden_ref_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasN) && !casN) |-> (!weN && (oeN || OE_TIED)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (rasN && casN));

endmodule

// File: rtl/edoWriteSeq.sv
module edoWriteSeq
  import edoSeqPkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 10,
  parameter int DQ_W  = 4,
  parameter int T_RCD = 2,
  parameter int T_WCS = 1,
  parameter int T_CAS = 2,
  parameter int T_CWD = 3,
  parameter int T_OEH = 1,
  parameter int T_RP  = 3,
  parameter int T_CP  = 2,
  parameter int T_REF = 3,
  parameter bit OE_TIED = 1'b0,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic              reqHidRef,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DQ_W-1:0]   reqWdata,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DQ_W-1:0]   doneRdata,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [ADDR_W-1:0] dramAddr,
  output logic [DQ_W-1:0]   dramDqOut,
  output logic              dramDqOe,
  input  logic [DQ_W-1:0]   dramDqIn
);

  strobeT strobe;

  edoSeqCtrl #(
    .T_RCD(T_RCD), .T_WCS(T_WCS), .T_CAS(T_CAS), .T_CWD(T_CWD),
    .T_OEH(T_OEH), .T_RP(T_RP), .T_CP(T_CP), .T_REF(T_REF),
    .OE_TIED(OE_TIED)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(opE'(reqOp)),
    .reqHidRef(reqHidRef), .reqReady(reqReady), .doneValid(doneValid),
    .rasN(dramRasN), .casN(dramCasN), .weN(dramWeN), .oeN(dramOeN),
    .strobe(strobe)
  );

  edoSeqData #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRow(reqRow),
    .reqCol(reqCol), .reqWdata(reqWdata), .dqIn(dramDqIn),
    .addr(dramAddr), .dqOut(dramDqOut), .dqOe(dramDqOe), .rdata(doneRdata)
  );

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> (dramOeN || OE_TIED));

  assert_row_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> !dramRasN);

endmodule

// File: tb/edoWriteSeq_test.sv
`timescale 1ns/1ps
module edoWriteSeq_test;
  localparam int T_RCD = 2, T_WCS = 1, T_CAS = 2, T_CWD = 3, T_OEH = 1;
  localparam int T_RP = 3, T_CP = 2, T_REF = 3;
  localparam int T_PRE = (T_RP > T_CP) ? T_RP : T_CP;
  localparam int E_LEN = T_RCD + T_WCS + T_CAS + T_PRE;
  localparam int L_LEN = T_RCD + T_CWD + T_CAS + T_PRE;
  localparam int M_LEN = T_RCD + T_CWD + T_OEH + T_CAS + T_PRE;
  localparam int H_ADD = T_RP + T_REF;
  localparam int TR = 28;

  logic clk = 0, rstN = 0, reqValid = 0, reqHidRef = 0;
  logic [1:0] reqOp = 0;
  logic [11:0] reqRow = 0;
  logic [9:0] reqCol = 0;
  logic [3:0] reqWdata = 0, dqIn = 0;
  logic reqReady, doneValid, rasN, casN, weN, oeN, dqOe;
  logic [3:0] doneRdata, dqOut;
  logic [11:0] addr;
  logic kReady, kDone, kRas, kCas, kWe, kOe, kDqOe;
  logic [3:0] kRdata, kDqOut;
  logic [11:0] kAddr;

  int checks = 0, errors = 0;
  logic [TR-1:0] tRas, tCas, tWe, tOe, tDqOe, tDone, tReady, uWe, uCas, uOe, uDone;
  logic [11:0] tAddr [TR];
  logic [3:0] tDq [TR];
  logic [3:0] tRd [TR];

  always #2.5 clk = ~clk;

  edoWriteSeq #(.T_RCD(T_RCD), .T_WCS(T_WCS), .T_CAS(T_CAS), .T_CWD(T_CWD),
    .T_OEH(T_OEH), .T_RP(T_RP), .T_CP(T_CP), .T_REF(T_REF), .OE_TIED(1'b0)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqHidRef(reqHidRef),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata), .reqReady(reqReady),
    .doneValid(doneValid), .doneRdata(doneRdata), .dramRasN(rasN), .dramCasN(casN),
    .dramWeN(weN), .dramOeN(oeN), .dramAddr(addr), .dramDqOut(dqOut),
    .dramDqOe(dqOe), .dramDqIn(dqIn));

  edoWriteSeq #(.T_RCD(T_RCD), .T_WCS(T_WCS), .T_CAS(T_CAS), .T_CWD(T_CWD),
    .T_OEH(T_OEH), .T_RP(T_RP), .T_CP(T_CP), .T_REF(T_REF), .OE_TIED(1'b1)) uutTied (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqHidRef(reqHidRef),
    .reqRow(reqRow), .reqCol(reqCol), .reqWdata(reqWdata), .reqReady(kReady),
    .doneValid(kDone), .doneRdata(kRdata), .dramRasN(kRas), .dramCasN(kCas),
    .dramWeN(kWe), .dramOeN(kOe), .dramAddr(kAddr), .dramDqOut(kDqOut),
    .dramDqOe(kDqOe), .dramDqIn(dqIn));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int firstAt(input logic [TR-1:0] v, input logic val, input int from);
    for (int i = from; i < TR; i++) if (from >= 0 && v[i] === val) return i;
    return -1;
  endfunction

  function automatic int countOf(input logic [TR-1:0] v, input logic val);
    int n = 0;
    for (int i = 0; i < TR; i++) if (v[i] === val) n++;
    return n;
  endfunction

  task automatic runReq(input logic [1:0] op, input logic hid, input logic [11:0] row,
                        input logic [9:0] col, input logic [3:0] data, input int hold);
    @(negedge clk);
    reqOp = op; reqHidRef = hid; reqRow = row; reqCol = col; reqWdata = data;
    reqValid = 1'b1;
    for (int i = 0; i < TR; i++) begin
      @(negedge clk);
      if (i >= hold) reqValid = 1'b0;
      tRas[i] = rasN; tCas[i] = casN; tWe[i] = weN; tOe[i] = oeN;
      tDqOe[i] = dqOe; tDone[i] = doneValid; tReady[i] = reqReady;
      tAddr[i] = addr; tDq[i] = dqOut; tRd[i] = doneRdata;
      uWe[i] = kWe; uCas[i] = kCas; uOe[i] = kOe; uDone[i] = kDone;
    end
  endtask

  task automatic checkBus();
    int bad = 0;
    for (int i = 0; i < TR; i++) if (tDqOe[i] && !tOe[i]) bad++;
    chk(bad == 0, "R5", "drive overlaps OE low", bad, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(rasN && casN && weN && oeN, "R1", "strobes high",
        int'({rasN, casN, weN, oeN}), 15);
    chk(!dqOe, "R1", "drive off", dqOe, 0);
    chk(reqReady && !doneValid, "R1", "ready/done", int'({reqReady, doneValid}), 2);
  endtask

  task automatic testEarly();
    int casF, weF, dIdx;
    runReq(2'd0, 1'b0, 12'h5A3, 10'h2C1, 4'h9, 0);
    casF = firstAt(tCas, 0, 0); weF = firstAt(tWe, 0, 0);
    chk(tRas[0] == 0 && tAddr[0] == 12'h5A3, "R6", "row with RAS fall", int'(tAddr[0]), 'h5A3);
    chk(casF - T_RCD >= 0 && tAddr[casF] == 12'h2C1, "R6", "column at CAS fall",
        int'(tAddr[casF]), 'h2C1);
    chk(casF - weF == T_WCS, "R2", "WE-to-CAS setup", casF - weF, T_WCS);
    chk(countOf(tOe, 0) == 0, "R2", "OE low cycles", countOf(tOe, 0), 0);
    chk(tDqOe[casF] && tDq[casF] == 4'h9, "R2", "data at CAS fall", int'(tDq[casF]), 9);
    dIdx = firstAt(tDone, 1, 0);
    chk(dIdx == E_LEN - 1 && countOf(tDone, 1) == 1, "R11", "done index", dIdx, E_LEN - 1);
    chk(tReady[E_LEN] == 1, "R11", "ready after done", tReady[E_LEN], 1);
    checkBus();
  endtask

  task automatic testLate();
    int casF, weF;
    runReq(2'd1, 1'b0, 12'h0F0, 10'h155, 4'h3, 0);
    casF = firstAt(tCas, 0, 0); weF = firstAt(tWe, 0, 0);
    chk(weF - casF == T_CWD, "R3", "CAS-to-WE delay", weF - casF, T_CWD);
    chk(countOf(tOe, 0) == 0, "R3", "OE low cycles", countOf(tOe, 0), 0);
    chk(firstAt(tDqOe, 1, 0) == weF && tDq[weF] == 4'h3, "R3", "drive starts at WE fall",
        firstAt(tDqOe, 1, 0), weF);
    chk(firstAt(tDone, 1, 0) == L_LEN - 1, "R11", "late done index",
        firstAt(tDone, 1, 0), L_LEN - 1);
    checkBus();
  endtask

  task automatic testRmw();
    int casF, weF, oeF, oeLast, dIdx;
    dqIn = 4'h6;
    runReq(2'd2, 1'b0, 12'h321, 10'h0AB, 4'hC, 0);
    casF = firstAt(tCas, 0, 0); weF = firstAt(tWe, 0, 0); oeF = firstAt(tOe, 0, 0);
    oeLast = firstAt(tOe, 1, oeF) - 1;
    chk(oeF == casF && countOf(tOe, 0) == T_CWD, "R4", "OE low window",
        countOf(tOe, 0), T_CWD);
    chk(weF - oeLast == T_OEH + 1, "R4", "OE high before WE", weF - oeLast, T_OEH + 1);
    dIdx = firstAt(tDone, 1, 0);
    chk(dIdx == M_LEN - 1, "R11", "rmw done index", dIdx, M_LEN - 1);
    chk(dIdx >= 0 && tRd[dIdx] == 4'h6, "R4", "read data", int'(tRd[dIdx]), 6);
    chk(firstAt(tDqOe, 1, 0) == weF, "R4", "drive at WE fall", firstAt(tDqOe, 1, 0), weF);
    checkBus();
    dqIn = 4'h0;
  endtask

  task automatic testHidden();
    int rasR, rasF2;
    runReq(2'd0, 1'b1, 12'h111, 10'h222, 4'h5, 0);
    rasR = firstAt(tRas, 1, 0);
    rasF2 = firstAt(tRas, 0, rasR);
    chk(rasR >= 0 && tCas[rasR] == 0, "R8", "CAS low at RAS rise", tCas[rasR], 0);
    chk(tWe[rasR] == 0 && tOe[rasR] == 1, "R8", "WE/OE at RAS rise",
        int'({tWe[rasR], tOe[rasR]}), 1);
    chk(rasF2 - rasR == T_RP, "R8", "refresh precharge", rasF2 - rasR, T_RP);
    chk(rasF2 >= 0 && tCas[rasF2] == 0 && tWe[rasF2] == 0 && tOe[rasF2] == 1, "R8",
        "strobes at refresh RAS fall", int'({tCas[rasF2], tWe[rasF2], tOe[rasF2]}), 1);
    chk(firstAt(tDone, 1, 0) == E_LEN + H_ADD - 1, "R11", "hidden done index",
        firstAt(tDone, 1, 0), E_LEN + H_ADD - 1);
    checkBus();
  endtask

  task automatic testNop();
    runReq(2'd3, 1'b0, 12'hFFF, 10'h3FF, 4'hF, 0);
    chk(countOf(tRas, 0) + countOf(tCas, 0) + countOf(tWe, 0) == 0, "R9",
        "strobe activity", countOf(tRas, 0) + countOf(tCas, 0) + countOf(tWe, 0), 0);
    chk(countOf(tDone, 1) == 0, "R9", "done pulses", countOf(tDone, 1), 0);
  endtask

  task automatic testBackToBack();
    int casF, casR, cas2, rasR, ras2;
    runReq(2'd0, 1'b0, 12'h070, 10'h007, 4'hA, E_LEN + 2);
    casF = firstAt(tCas, 0, 0); casR = firstAt(tCas, 1, casF); cas2 = firstAt(tCas, 0, casR);
    rasR = firstAt(tRas, 1, 0); ras2 = firstAt(tRas, 0, rasR);
    chk(countOf(tDone, 1) == 2, "R7", "two requests served", countOf(tDone, 1), 2);
    chk(cas2 > 0 && cas2 - casR >= T_CP, "R7", "CAS precharge", cas2 - casR, T_CP);
    chk(ras2 > 0 && ras2 - rasR >= T_RP, "R7", "RAS precharge", ras2 - rasR, T_RP);
    checkBus();
  endtask

  task automatic testTied();
    int casF, casR;
    runReq(2'd0, 1'b0, 12'h246, 10'h135, 4'h7, 0);
    casF = firstAt(uCas, 0, 0); casR = firstAt(uCas, 1, casF);
    chk(countOf(uOe, 1) == 0, "R10", "OE stays low", countOf(uOe, 1), 0);
    chk(casR > 0 && uWe[casR] == 0 && uWe[casR + 1] == 1, "R10",
        "WE pulse in CAS high", int'({uWe[casR], uWe[casR + 1]}), 1);
    chk(countOf(uDone, 1) == 1, "R10", "early served", countOf(uDone, 1), 1);
    runReq(2'd1, 1'b0, 12'h246, 10'h135, 4'h7, 0);
    chk(countOf(uCas, 0) == 0 && countOf(uDone, 1) == 0, "R10", "late ignored",
        countOf(uDone, 1), 0);
    runReq(2'd2, 1'b0, 12'h246, 10'h135, 4'h7, 0);
    chk(countOf(uCas, 0) == 0 && countOf(uDone, 1) == 0, "R10", "rmw ignored",
        countOf(uDone, 1), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEarly();
    testLate();
    testRmw();
    testHidden();
    testNop();
    testBackToBack();
    testTied();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule